// File: doc/BRIEF.md
# Edge-Triggered Fault Blanking Unit

This unit qualifies recoverable fault inputs for a PWM timer. Every fault line has a paired waveform input, an edge selector, an 8-bit window length and a prescale enable. When the selected transition of the paired waveform is seen, the unit opens a blanking window. While the window is open, the fault line is masked, so switching noise that follows an output transition cannot trip the fault logic.

The window counter decrements either once per clock or once every 64 clocks, depending on the prescale enable. A qualifying edge that arrives while a window is already open reloads the full count. All channels are identical and run independently. Each channel provides the qualified fault and a flag that is high while its window is open.

Top module: `fault_blank_unit`

## Requirements
- R1: While reset is asserted and after it is released, `blank_o` is 0 for every channel and `fault_o` equals `fault_i`.
- R2: The 2-bit edge selector per channel uses this encoding: 0 = disabled, 1 = rising edge of `wave_i`, 2 = falling edge, 3 = either edge. A transition that the selector does not choose opens no window.
- R3: With the prescaler off and length N, `blank_o` goes high on the clock edge that samples a qualifying transition of `wave_i`. It then stays high for exactly N cycles. A length of 240 gives 240 cycles.
- R4: With the prescaler on and length N, the window lasts N×64 cycles. A length of 10 gives 640 cycles, and a length of 1 gives 64 cycles.
- R5: While `blank_o` of a channel is high, that channel's `fault_o` is 0, whatever the value of `fault_i`.
- R6: If a fault is still asserted when the window ends, it appears on `fault_o` in the first cycle in which `blank_o` is low.
- R7: A qualifying edge during an open window restarts the window with the full programmed length.
- R8: A length of 0 opens no window.
- R9: The channels are independent. An edge on one channel's waveform never raises `blank_o` on another channel.
- R10: Outside a window, `fault_o` follows `fault_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wave_i | input | NUM_CH | Waveform output that each channel watches |
| fault_i | input | NUM_CH | Raw recoverable fault inputs |
| edge_sel_i | input | 2*NUM_CH | Edge selector per channel (0 off, 1 rise, 2 fall, 3 both) |
| blank_len_i | input | LEN_W*NUM_CH | Window length per channel, in counter ticks |
| presc_en_i | input | NUM_CH | Per-channel enable of the divide-by-PRESC_DIV tick |
| fault_o | output | NUM_CH | Qualified fault |
| blank_o | output | NUM_CH | Window open flag |

## Verification
The bench builds the unit with its default parameters: two channels, an 8-bit length and a prescale of 64. With these values the bench can reach the 240-cycle direct window and the 640-cycle prescaled window within a short run. Having two channels also lets it show that an edge on one channel leaves the other untouched. A table covers every selector value against both edge directions, together with the zero-length and single-tick prescaled cases. Directed tests then cover reset, a restart in the middle of a window, and channel isolation.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/fb_edge_det.sv
module fb_edge_det
  import fb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wave_i,
  input  edge_sel_e sel_i,
  output logic      start_o
);
  logic wave_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_i;
  end

  assign rise = wave_i & ~wave_q;
  assign fall = ~wave_i & wave_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: start_o = rise;
      EDGE_FALL: start_o = fall;
      EDGE_BOTH: start_o = rise | fall;
      default:   start_o = 1'b0;
    endcase
  end

  AST_OFF_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EDGE_OFF) |-> !start_o); // R2
  AST_STEADY_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_i == wave_q) |-> !start_o); // R2
endmodule

// File: rtl/fb_blank_timer.sv
module fb_blank_timer #(
  parameter int LEN_W     = 8,
  parameter int PRESC_DIV = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             presc_en_i,
  output logic             active_o
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(PRESC_DIV - 1);

  logic [LEN_W-1:0] cnt_q;
  logic [PW-1:0]    presc_q;
  logic             tick;

  assign tick = !presc_en_i || (presc_q == PRESC_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      presc_q <= '0;
    end else if (start_i) begin
      cnt_q   <= len_i;
      presc_q <= '0;
    end else if (cnt_q != '0) begin
      if (tick) begin
        cnt_q   <= cnt_q - 1'b1;
        presc_q <= '0;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  assign active_o = (cnt_q != '0);

  AST_DIRECT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start_i && !presc_en_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_PRESC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start_i && presc_en_i && presc_q != PRESC_LAST) |=> $stable(cnt_q)); // R4
  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_i == '0) |=> !active_o); // R8
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_i != '0) |=> active_o); // R7
  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_i) |=> !active_o); // R2
endmodule

// File: rtl/fault_blank_unit.sv
module fault_blank_unit
  import fb_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int LEN_W     = 8,
  parameter int PRESC_DIV = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       wave_i,
  input  logic [NUM_CH-1:0]       fault_i,
  input  logic [2*NUM_CH-1:0]     edge_sel_i,
  input  logic [LEN_W*NUM_CH-1:0] blank_len_i,
  input  logic [NUM_CH-1:0]       presc_en_i,
  output logic [NUM_CH-1:0]       fault_o,
  output logic [NUM_CH-1:0]       blank_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic start;

    fb_edge_det u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wave_i (wave_i[c]),
      .sel_i  (edge_sel_e'(edge_sel_i[2*c +: 2])),
      .start_o(start)
    );

    fb_blank_timer #(.LEN_W(LEN_W), .PRESC_DIV(PRESC_DIV)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start),
      .len_i     (blank_len_i[LEN_W*c +: LEN_W]),
      .presc_en_i(presc_en_i[c]),
      .active_o  (blank_o[c])
    );

    assign fault_o[c] = fault_i[c] & ~blank_o[c];

    AST_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blank_o[c] |-> !fault_o[c]); // R5
    AST_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!blank_o[c] && fault_i[c]) |-> fault_o[c]); // R10
  end
endmodule

// File: tb/sim_fault_blank_unit.sv
`timescale 1ns/1ps
module sim_fault_blank_unit;
  localparam int NC = 2;
  localparam int LW = 8;

  typedef struct packed {
    logic [1:0]  sel;
    logic [7:0]  len;
    logic        pre;
    logic        fall;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{2'd1, 8'd5,   1'b0, 1'b0, 16'd5},
    '{2'd1, 8'd5,   1'b0, 1'b1, 16'd0},
    '{2'd2, 8'd7,   1'b0, 1'b1, 16'd7},
    '{2'd2, 8'd7,   1'b0, 1'b0, 16'd0},
    '{2'd3, 8'd3,   1'b0, 1'b0, 16'd3},
    '{2'd3, 8'd3,   1'b0, 1'b1, 16'd3},
    '{2'd0, 8'd9,   1'b0, 1'b0, 16'd0},
    '{2'd0, 8'd9,   1'b0, 1'b1, 16'd0},
    '{2'd1, 8'd240, 1'b0, 1'b0, 16'd240},
    '{2'd1, 8'd10,  1'b1, 1'b0, 16'd640},
    '{2'd1, 8'd0,   1'b0, 1'b0, 16'd0},
    '{2'd3, 8'd1,   1'b1, 1'b1, 16'd64}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] wave_v = '0, flt_v = '0, pre_v = '0;
  logic [2*NC-1:0] sel_v = '0;
  logic [LW*NC-1:0] len_v = '0;
  logic [NC-1:0] flt_o, blk_o;
  int checks = 0, errors = 0;
  bit other_hit;

  always #2.5 clk = ~clk;

  fault_blank_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .wave_i(wave_v), .fault_i(flt_v),
    .edge_sel_i(sel_v), .blank_len_i(len_v), .presc_en_i(pre_v),
    .fault_o(flt_o), .blank_o(blk_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts window cycles on channel ch starting at the next negedge
  task automatic measure(input int ch, input int exp, input string req);
    int n = 0;
    bit leak = 0;
    other_hit = 0;
    @(negedge clk);
    while (blk_o[ch] && n < 2000) begin
      if (flt_o[ch]) leak = 1;
      if (blk_o[1-ch]) other_hit = 1;
      n++;
      @(negedge clk);
    end
    check(n == exp, req, n, exp);
    check(!leak, "R5 masked during window", int'(leak), 0);
    check(flt_o[ch] == 1'b1, "R6/R10 fault passes after window", int'(flt_o[ch]), 1);
  endtask

  task automatic setup(input int ch, input logic [1:0] s, input logic [7:0] l,
                       input logic p, input logic lvl);
    sel_v[2*ch +: 2] = 2'd0;
    wave_v[ch] = lvl;
    repeat (2) @(negedge clk);
    sel_v[2*ch +: 2] = s;
    len_v[LW*ch +: LW] = l;
    pre_v[ch] = p;
    flt_v[ch] = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    flt_v = 2'b11;
    #12;
    check(blk_o == '0, "R1 blank low in reset", int'(blk_o), 0);
    check(flt_o == 2'b11, "R1 fault passes in reset", int'(flt_o), 3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(blk_o == '0, "R1 blank low after reset", int'(blk_o), 0);
    check(flt_o == flt_v, "R1 fault follows after reset", int'(flt_o), int'(flt_v));

    // table: R2 selector, R3 direct, R4 prescaled, R8 zero length
    foreach (TBL[i]) begin
      setup(0, TBL[i].sel, TBL[i].len, TBL[i].pre, TBL[i].fall);
      wave_v[0] = ~TBL[i].fall;
      measure(0, int'(TBL[i].exp), $sformatf("R2/R3/R4/R8 row %0d window", i));
      check(!other_hit, "R9 other channel idle", int'(other_hit), 0);
    end

    // R7 restart mid-window
    setup(0, 2'd3, 8'd10, 1'b0, 1'b0);
    wave_v[0] = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(blk_o[0], "R7 window open before restart", int'(blk_o[0]), 1);
    end
    wave_v[0] = 1'b0;
    measure(0, 10, "R7 restart length");

    // R9 channel 1 alone, channel 0 armed but static
    setup(0, 2'd3, 8'd20, 1'b0, 1'b0);
    setup(1, 2'd1, 8'd6, 1'b0, 1'b0);
    wave_v[1] = 1'b1;
    measure(1, 6, "R9 channel 1 window");
    check(!other_hit, "R9 channel 0 untouched", int'(other_hit), 0);

    // R10 fault toggles outside window are seen in the same cycle
    flt_v[0] = 1'b0;
    #1;
    check(flt_o[0] == 1'b0, "R10 fault low follows", int'(flt_o[0]), 0);
    flt_v[0] = 1'b1;
    #1;
    check(flt_o[0] == 1'b1, "R10 fault high follows", int'(flt_o[0]), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule